// File: doc/BRIEF.md
# Serial Flash Write Guard

This unit sits beside the command decoder of a serial flash controller and owns the small status register. That register holds a write-enable latch, a busy indication, a two-bit protection code and a bit that arms the hardware write-protect pin. Each decoded write-type request is checked against this register in one clock cycle. Program, sector erase, block erase, chip erase and status write all count as write-type requests. The unit then returns a grant or a deny. A granted array operation is handed to the write engine, and the unit follows that engine's busy signal so that it knows when the operation has finished.

The protection code fences off a region at the top of the array. Code 0 fences nothing. Code 1 fences the upper quarter, code 2 the upper half and code 3 the whole array. The array size is a parameter, so these boundaries scale with it. An erase is judged by the highest address of the region it would clear, which means that any overlap with the fenced region denies the erase. The status byte is always present on an output, so reading it back needs no handshake.

Top module: `sflash_wprot_unit`

## Requirements
- R1: After reset the status byte reads 0x00: latch clear, not busy, protection code 00, pin arming bit clear.
- R2: A program, erase or status-write request is denied while the write-enable latch (status bit 1) is clear.
- R3: A write-enable strobe sets status bit 1 when the unit is not busy. A write-disable strobe clears it at either level of the active-low protect pin.
- R4: With protection code c in status bits 3:2, an array request is denied when c is nonzero and its last address is at or above the fence. The fence is 3/4 of the array size for c=1, 1/2 for c=2 and 0 for c=3. The last address is the target address for a program. For a sector erase it is the target with its low log2(SECTOR_BYTES) bits set, and for a block erase the target with its low log2(BLOCK_BYTES) bits set.
- R5: Chip erase is granted only when the protection code is 00 (and the latch is set and the unit is idle).
- R6: A granted status write loads status bits 3:2 from data bits 3:2 and status bit 7 from data bit 7. The other data bits are ignored. The same grant clears the write-enable latch.
- R7: When status bit 7 is set and the protect pin is low, a status write is denied and status bits 7:2 stay unchanged.
- R8: After a granted program or erase, the latch clears once the engine has raised busy and then dropped it.
- R9: Status bit 0 is set from the cycle after an array grant until the operation completes, and it also follows the engine busy input with one cycle of delay. While bit 0 is set, every write-type request is denied and the write-enable and write-disable strobes have no effect.
- R10: The response (rsp_valid, rsp_grant) appears in the cycle after a write-type strobe and lasts one cycle. Write-enable and write-disable strobes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wren | input | 1 | Write-enable strobe |
| cmd_wrdi | input | 1 | Write-disable strobe |
| cmd_wrsr | input | 1 | Status-write strobe |
| cmd_prog | input | 1 | Program strobe |
| cmd_serase | input | 1 | Sector erase strobe |
| cmd_berase | input | 1 | Block erase strobe |
| cmd_cerase | input | 1 | Chip erase strobe |
| tgt_addr | input | ADDR_W | Target byte address |
| sr_wdata | input | 8 | Data byte for a status write |
| wp_n | input | 1 | Write-protect pin level, active low |
| eng_busy | input | 1 | Busy signal from the write engine |
| rsp_valid | output | 1 | Response strobe |
| rsp_grant | output | 1 | 1 = request granted, 0 = denied |
| status_o | output | 8 | Status byte: bit7 pin arming, bits 3:2 protection code, bit1 latch, bit0 busy |

## Verification
The assertions assume that at most one command strobe is high in any cycle. The bench keeps to this by driving each strobe for exactly one cycle with idle cycles between strobes. The assertions also assume that the write engine raises busy only after a grant. The bench models the engine in that way, starting busy one cycle after each granted array request and holding it for several cycles, so the completion rule is always exercised in the intended order.

// File: rtl/sflash_wprot_pkg.sv
package sflash_wprot_pkg;

  typedef enum logic [2:0] {
    RQ_NONE   = 3'd0,
    RQ_PROG   = 3'd1,
    RQ_SERASE = 3'd2,
    RQ_BERASE = 3'd3,
    RQ_CERASE = 3'd4,
    RQ_WRSR   = 3'd5
  } req_kind_e;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_WAIT = 2'd1,
    OP_RUN  = 2'd2
  } op_state_e;

  localparam int SR_BUSY_BIT = 0;
  localparam int SR_WEL_BIT  = 1;
  localparam int SR_BP_LO    = 2;
  localparam int SR_BP_HI    = 3;
  localparam int SR_ARM_BIT  = 7;

endpackage

// File: rtl/sflash_prot_range.sv
module sflash_prot_range
  import sflash_wprot_pkg::*;
#(
  parameter int ARRAY_BYTES  = 131072,
  parameter int SECTOR_BYTES = 4096,
  parameter int BLOCK_BYTES  = 32768,
  parameter int ADDR_W       = $clog2(ARRAY_BYTES)
) (
  input  req_kind_e         kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        bp,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] SECT_MASK = ADDR_W'(SECTOR_BYTES - 1);
  localparam logic [ADDR_W-1:0] BLK_MASK  = ADDR_W'(BLOCK_BYTES - 1);
  localparam logic [ADDR_W-1:0] TOP_ADDR  = ADDR_W'(ARRAY_BYTES - 1);
  localparam logic [ADDR_W-1:0] FENCE_Q   = ADDR_W'(ARRAY_BYTES - ARRAY_BYTES / 4);
  localparam logic [ADDR_W-1:0] FENCE_H   = ADDR_W'(ARRAY_BYTES / 2);

  logic [ADDR_W-1:0] last_addr;
  logic [ADDR_W-1:0] fence;

  always_comb begin
    unique case (kind)
      RQ_SERASE: last_addr = addr | SECT_MASK;
      RQ_BERASE: last_addr = addr | BLK_MASK;
      RQ_CERASE: last_addr = TOP_ADDR;
      default:   last_addr = addr;
    endcase
  end

  always_comb begin
    unique case (bp)
      2'b01:   fence = FENCE_Q;
      2'b10:   fence = FENCE_H;
      default: fence = '0;
    endcase
  end

  assign hit = (bp != 2'b00) && (last_addr >= fence);

endmodule

// File: rtl/sflash_status_reg.sv
module sflash_status_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       set_wel,
  input  logic       clr_wel,
  input  logic       ld_sr,
  input  logic [7:0] sr_data,
  output logic       wel,
  output logic [1:0] bp,
  output logic       arm
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wel <= 1'b0;
      bp  <= 2'b00;
      arm <= 1'b0;
    end else begin
      if (clr_wel)      wel <= 1'b0;
      else if (set_wel) wel <= 1'b1;
      if (ld_sr) begin
        bp  <= sr_data[3:2];
        arm <= sr_data[7];
      end
    end
  end
endmodule

// File: rtl/sflash_op_tracker.sv
module sflash_op_tracker
  import sflash_wprot_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic eng_busy,
  output logic busy,
  output logic done
);
  op_state_e st;
  logic      eng_q;

  assign busy = eng_q || (st != OP_IDLE);
  assign done = (st == OP_RUN) && !eng_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= OP_IDLE;
      eng_q <= 1'b0;
    end else begin
      eng_q <= eng_busy;
      unique case (st)
        OP_IDLE: if (start) st <= OP_WAIT;
        OP_WAIT: if (eng_q) st <= OP_RUN;
        OP_RUN:  if (!eng_q) st <= OP_IDLE;
        default: st <= OP_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sflash_wprot_unit.sv
module sflash_wprot_unit
  import sflash_wprot_pkg::*;
#(
  parameter int ARRAY_BYTES  = 131072,
  parameter int SECTOR_BYTES = 4096,
  parameter int BLOCK_BYTES  = 32768,
  parameter int ADDR_W       = $clog2(ARRAY_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic              cmd_prog,
  input  logic              cmd_serase,
  input  logic              cmd_berase,
  input  logic              cmd_cerase,
  input  logic [ADDR_W-1:0] tgt_addr,
  input  logic [7:0]        sr_wdata,
  input  logic              wp_n,
  input  logic              eng_busy,
  output logic              rsp_valid,
  output logic              rsp_grant,
  output logic [7:0]        status_o
);
  req_kind_e  kind;
  logic       hit, busy, done;
  logic       wel, arm;
  logic [1:0] bp;
  logic       is_array, allow, grant;
  logic       set_wel, clr_wel, ld_sr, start;

  always_comb begin
    if (cmd_wrsr)        kind = RQ_WRSR;
    else if (cmd_prog)   kind = RQ_PROG;
    else if (cmd_serase) kind = RQ_SERASE;
    else if (cmd_berase) kind = RQ_BERASE;
    else if (cmd_cerase) kind = RQ_CERASE;
    else                 kind = RQ_NONE;
  end

  sflash_prot_range #(
    .ARRAY_BYTES (ARRAY_BYTES),
    .SECTOR_BYTES(SECTOR_BYTES),
    .BLOCK_BYTES (BLOCK_BYTES),
    .ADDR_W      (ADDR_W)
  ) u_range (
    .kind(kind),
    .addr(tgt_addr),
    .bp  (bp),
    .hit (hit)
  );

  assign is_array = (kind != RQ_NONE) && (kind != RQ_WRSR);

  always_comb begin
    if (kind == RQ_WRSR) allow = !(arm && !wp_n);
    else                 allow = !hit;
  end

  assign grant   = (kind != RQ_NONE) && wel && !busy && allow;
  assign ld_sr   = grant && (kind == RQ_WRSR);
  assign start   = grant && is_array;
  assign set_wel = cmd_wren && !busy;
  assign clr_wel = (cmd_wrdi && !busy) || done || ld_sr;

  sflash_status_reg u_sr (
    .clk    (clk),
    .rst    (rst),
    .set_wel(set_wel),
    .clr_wel(clr_wel),
    .ld_sr  (ld_sr),
    .sr_data(sr_wdata),
    .wel    (wel),
    .bp     (bp),
    .arm    (arm)
  );

  sflash_op_tracker u_op (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .eng_busy(eng_busy),
    .busy    (busy),
    .done    (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_grant <= 1'b0;
    end else begin
      rsp_valid <= (kind != RQ_NONE);
      rsp_grant <= grant;
    end
  end

  always_comb begin
    status_o              = 8'h00;
    status_o[SR_ARM_BIT]  = arm;
    status_o[SR_BP_HI:SR_BP_LO] = bp;
    status_o[SR_WEL_BIT]  = wel;
    status_o[SR_BUSY_BIT] = busy;
  end

endmodule

// File: rtl/sflash_wprot_chk.sv
module sflash_wprot_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_wren,
  input logic       cmd_wrdi,
  input logic       cmd_wrsr,
  input logic       cmd_prog,
  input logic       cmd_serase,
  input logic       cmd_berase,
  input logic       cmd_cerase,
  input logic       wp_n,
  input logic       rsp_valid,
  input logic       rsp_grant,
  input logic [7:0] status_o
);
  logic wr_req;
  assign wr_req = cmd_wrsr || cmd_prog || cmd_serase || cmd_berase || cmd_cerase;

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_wren, cmd_wrdi, cmd_wrsr, cmd_prog, cmd_serase, cmd_berase, cmd_cerase})); // R10

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(wr_req)); // R10

  AST_REQ_GIVES_RSP: assert property (@(posedge clk) disable iff (rst)
    wr_req |=> rsp_valid); // R10

  AST_DENY_NO_LATCH: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !status_o[1]) |=> !rsp_grant); // R2

  AST_WREN_SETS: assert property (@(posedge clk) disable iff (rst)
    (cmd_wren && !status_o[0]) |=> status_o[1]); // R3

  AST_CHIP_FENCED: assert property (@(posedge clk) disable iff (rst)
    (cmd_cerase && status_o[3:2] != 2'b00) |=> !rsp_grant); // R5

  AST_PIN_LOCK: assert property (@(posedge clk) disable iff (rst)
    (cmd_wrsr && status_o[7] && !wp_n) |=> (!rsp_grant && $stable(status_o[7:2]))); // R7

  AST_BUSY_DENY: assert property (@(posedge clk) disable iff (rst)
    (wr_req && status_o[0]) |=> !rsp_grant); // R9
endmodule

bind sflash_wprot_unit sflash_wprot_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_wren  (cmd_wren),
  .cmd_wrdi  (cmd_wrdi),
  .cmd_wrsr  (cmd_wrsr),
  .cmd_prog  (cmd_prog),
  .cmd_serase(cmd_serase),
  .cmd_berase(cmd_berase),
  .cmd_cerase(cmd_cerase),
  .wp_n      (wp_n),
  .rsp_valid (rsp_valid),
  .rsp_grant (rsp_grant),
  .status_o  (status_o)
);

// File: tb/sflash_wprot_unit_test.sv
`timescale 1ns/1ps
module sflash_wprot_unit_test;
  localparam int ARR  = 131072;
  localparam int SECT = 4096;
  localparam int BLK  = 32768;
  localparam int AW   = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0, cmd_prog = 0;
  logic cmd_serase = 0, cmd_berase = 0, cmd_cerase = 0;
  logic [AW-1:0] tgt_addr = '0;
  logic [7:0] sr_wdata = '0;
  logic wp_n = 1'b1;
  logic eng_busy = 1'b0;
  logic rsp_valid, rsp_grant;
  logic [7:0] status_o;

  int n_chk = 0;
  int n_fail = 0;
  logic got_v, got_g;

  always #5 clk = ~clk;

  sflash_wprot_unit #(.ARRAY_BYTES(ARR), .SECTOR_BYTES(SECT), .BLOCK_BYTES(BLK), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .cmd_wren(cmd_wren), .cmd_wrdi(cmd_wrdi), .cmd_wrsr(cmd_wrsr),
    .cmd_prog(cmd_prog), .cmd_serase(cmd_serase), .cmd_berase(cmd_berase),
    .cmd_cerase(cmd_cerase), .tgt_addr(tgt_addr), .sr_wdata(sr_wdata), .wp_n(wp_n),
    .eng_busy(eng_busy), .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .status_o(status_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // kind: 0 wren 1 wrdi 2 wrsr 3 prog 4 serase 5 berase 6 cerase
  task automatic issue(input int kind, input int addr, input logic [7:0] d);
    @(negedge clk);
    tgt_addr = AW'(addr);
    sr_wdata = d;
    cmd_wren   = (kind == 0);
    cmd_wrdi   = (kind == 1);
    cmd_wrsr   = (kind == 2);
    cmd_prog   = (kind == 3);
    cmd_serase = (kind == 4);
    cmd_berase = (kind == 5);
    cmd_cerase = (kind == 6);
    @(negedge clk);
    got_v = rsp_valid;
    got_g = rsp_grant;
    {cmd_wren, cmd_wrdi, cmd_wrsr, cmd_prog, cmd_serase, cmd_berase, cmd_cerase} = '0;
  endtask

  task automatic run_engine();
    eng_busy = 1'b1;
    repeat (4) @(negedge clk);
    eng_busy = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  function automatic bit fenced(input int code, input int kind, input int addr);
    int last, fence;
    case (kind)
      4: last = addr | (SECT - 1);
      5: last = addr | (BLK - 1);
      6: last = ARR - 1;
      default: last = addr;
    endcase
    fence = (code == 1) ? ARR - ARR / 4 : (code == 2) ? ARR / 2 : 0;
    return (code != 0) && (last >= fence);
  endfunction

  task automatic set_code(input int code);
    issue(0, 0, 8'h00);
    issue(2, 0, 8'(code << 2));
    chk("R6 grant", got_g, 1);
    chk("R6 code", status_o[3:2], code);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual expired expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 status", status_o, 8'h00);

    issue(3, 0, 8'h00);
    chk("R2 prog no latch valid", got_v, 1);
    chk("R2 prog no latch grant", got_g, 0);
    issue(2, 0, 8'h0C);
    chk("R2 wrsr no latch", got_g, 0);
    chk("R2 code kept", status_o[3:2], 0);

    issue(0, 0, 8'h00);
    chk("R10 wren no rsp", got_v, 0);
    chk("R3 latch set", status_o, 8'h02);
    wp_n = 1'b0;
    issue(1, 0, 8'h00);
    chk("R3 wrdi with pin low", status_o[1], 0);
    chk("R10 wrdi no rsp", got_v, 0);
    wp_n = 1'b1;

    // status write: other bits ignored, latch clears
    issue(0, 0, 8'h00);
    issue(2, 0, 8'h73);
    chk("R6 grant", got_g, 1);
    chk("R6 status", status_o, 8'h00);
    issue(0, 0, 8'h00);
    issue(2, 0, 8'h88);
    chk("R6 arm+code", status_o, 8'h88);
    wp_n = 1'b0;
    issue(0, 0, 8'h00);
    issue(2, 0, 8'h00);
    chk("R7 denied", got_g, 0);
    chk("R7 unchanged", status_o[7:2], 6'h22);
    wp_n = 1'b1;
    issue(2, 0, 8'h00);
    chk("R7 pin high grant", got_g, 1);
    chk("R7 cleared", status_o, 8'h00);

    // busy behaviour
    issue(0, 0, 8'h00);
    issue(3, 16, 8'h00);
    chk("R9 grant", got_g, 1);
    chk("R9 busy after grant", status_o[0], 1);
    eng_busy = 1'b1;
    issue(1, 0, 8'h00);
    chk("R9 wrdi ignored", status_o[1], 1);
    issue(3, 32, 8'h00);
    chk("R9 busy deny", got_g, 0);
    chk("R9 busy bit", status_o[0], 1);
    eng_busy = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 latch cleared", status_o[1:0], 0);
    issue(0, 0, 8'h00);
    chk("R9 wren after idle", status_o[1], 1);
    issue(1, 0, 8'h00);

    // sweep
    for (int code = 0; code < 4; code++) begin
      set_code(code);
      for (int a = 0; a < ARR; a += 8192) begin
        for (int k = 3; k <= 5; k++) begin
          issue(0, 0, 8'h00);
          issue(k, a + 12'hABC, 8'h00);
          chk("R4 sweep", got_g, !fenced(code, k, a + 12'hABC));
          if (got_g) begin
            run_engine();
            chk("R8 latch after op", status_o[1:0], 0);
          end else begin
            issue(1, 0, 8'h00);
          end
        end
      end
      issue(0, 0, 8'h00);
      issue(6, 0, 8'h00);
      chk("R5 chip erase", got_g, code == 0);
      if (got_g) run_engine();
      else issue(1, 0, 8'h00);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule